// File: doc/BRIEF.md
# Floating-Point Condition Flag and Branch Unit

This block is the control half of a single-precision floating-point coprocessor. It owns the coprocessor's control/status word, whose bit 23 is the compare condition flag. Each cycle it can accept one decoded operation, together with the register index fields and the operand values. Compare operations order two IEEE-754 single-precision operands and write the outcome into the flag. Conditional branches read the flag and produce a taken/not-taken decision. The likely variant also tells the fetch side to skip the delay slot when the branch is not taken.

The block also handles the moves between the integer and coprocessor register files. A floating-point register value moves to an integer register with sign extension. The control registers can be read into an integer register and written from one, each under its own index restrictions. Instruction fetch, the program-counter datapath and the floating-point arithmetic sit outside this block. It receives operation codes and operand values, and it returns the control word, a registered integer write-back and a registered branch decision.

Top module: `fp_cond_branch`

## Requirements
- R1: After reset the control word `ctrlStatus` is 0 and `condFlag`, `gprWe`, `brValid`, `brTaken` and `brSkipSlot` are low. `gprIdx` and `gprData` are 0 in every cycle in which `gprWe` is low.
- R2: The always-false compare (opCode 1) clears bit 23 of the control word whatever the operands are. All other bits of the word keep their values. The new value is visible in the cycle after the operation.
- R3: The compares equal (opCode 2), less-than (opCode 3) and less-or-equal (opCode 4) test the relation `fsVal` op `ftVal`. Each sets bit 23 when the relation holds and clears it otherwise. All other bits keep their values, and `condFlag` always equals bit 23.
- R4: Compares follow IEEE single-precision ordering. +0 and -0 are equal. A negative value is below every positive value, and among negatives the larger magnitude is the smaller value.
- R5: When either operand is a NaN (exponent all ones, fraction non-zero), the equal, less-than and less-or-equal compares all clear the flag.
- R6: Branch-on-false (opCode 5) is taken when the flag is 0, and branch-on-true (opCode 6) is taken when it is 1. `brValid` and `brTaken` are reported in the cycle after the operation. A branch issued in the cycle right after a compare uses that compare's result.
- R7: Branch-on-false-likely (opCode 7) and branch-on-true-likely (opCode 8) decide the branch the same way. When not taken they raise `brSkipSlot`, which annuls the delay slot and adds 4 to the program counter. `brSkipSlot` is never raised for a taken branch or for the plain forms.
- R8: A control read (opCode 10) writes integer register rt only when the fs index is 0 or 31. Register 0 reads as the constant parameter `CTRL0_VAL` (default 0x00002E30) and register 31 reads as the control word. The 32-bit value is sign-extended to 64 bits. Any other fs index, or rt equal to 0, produces no write.
- R9: A control write (opCode 11) loads `gprIn` into the control word only when the fs index is 31. For any other index the write is ignored and the control word is unchanged.
- R10: A move from a floating-point register (opCode 9) writes `fsVal` sign-extended to 64 bits into integer register rt. It is suppressed when rt is 0.
- R11: Opcode 0 is a no-op. In `regFields`, bits 20:16 hold rt/ft and bits 15:11 hold fs, using the bit numbering of the instruction word.
- R12: While `opValid` is low, the operation code has no effect. No write-back, no branch report and no control-word change follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Decoded operation code (see R2 to R11) |
| regFields | input | 10 | Instruction bits 20:11: rt/ft at 20:16, fs at 15:11 |
| fsVal | input | 32 | Value of floating-point register fs |
| ftVal | input | 32 | Value of floating-point register ft |
| gprIn | input | 32 | Low word of integer register rt |
| ctrlStatus | output | 32 | Control/status word (control register 31) |
| condFlag | output | 1 | Compare condition flag (bit 23 of the word) |
| gprWe | output | 1 | Integer register write-back strobe |
| gprIdx | output | 5 | Integer register written |
| gprData | output | 64 | Sign-extended write-back value |
| brValid | output | 1 | A branch was decided this cycle |
| brTaken | output | 1 | The branch is taken |
| brSkipSlot | output | 1 | Not-taken likely branch: skip the delay slot |

## Verification
A wrong flag shows up on `condFlag` and `ctrlStatus` one cycle after the compare. It shows again in the first branch that follows, because the taken and skip outputs would disagree with the model. A corrupted bit elsewhere in the control word stays visible on `ctrlStatus` until the next full write, and a control read copies it onto `gprData`. The model is compared against every output on every clock, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CMP_F  = 4'd1,
    OP_CMP_EQ = 4'd2,
    OP_CMP_LT = 4'd3,
    OP_CMP_LE = 4'd4,
    OP_BR_F   = 4'd5,
    OP_BR_T   = 4'd6,
    OP_BR_FL  = 4'd7,
    OP_BR_TL  = 4'd8,
    OP_MOV_FP = 4'd9,
    OP_CTL_RD = 4'd10,
    OP_CTL_WR = 4'd11
  } fccOp_e;

  typedef enum logic [1:0] {
    REL_EQ    = 2'd0,
    REL_LT    = 2'd1,
    REL_LE    = 2'd2,
    REL_FALSE = 2'd3
  } fccRel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    cmpEn;
    fccRel_e rel;
    logic    ctlWr;
    logic    ctlRd;
    logic    fpMove;
  } fccStrobe_t;

endpackage

// File: rtl/fcc_compare.sv
// IEEE single-precision ordering of two operands (combinational)
module fcc_compare #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         isEq,
  output logic         isLt
);

  logic signA, signB;
  logic nanA, nanB, zeroA, zeroB, unordered;
  logic [W-2:0] magA, magB;
  logic eqRaw, ltRaw;

  assign signA = opA[W-1];
  assign signB = opB[W-1];
  assign magA  = opA[W-2:0];
  assign magB  = opB[W-2:0];
  assign nanA  = (&opA[W-2:MAN_W]) & (|opA[MAN_W-1:0]);
  assign nanB  = (&opB[W-2:MAN_W]) & (|opB[MAN_W-1:0]);
  assign zeroA = ~|magA;
  assign zeroB = ~|magB;
  assign unordered = nanA | nanB;

  always_comb begin
    eqRaw = (opA == opB) | (zeroA & zeroB);
    if (zeroA && zeroB) begin
      ltRaw = 1'b0;
    end else begin
      case ({signA, signB})
        2'b10:   ltRaw = 1'b1;
        2'b01:   ltRaw = 1'b0;
        2'b00:   ltRaw = magA < magB;
        default: ltRaw = magB < magA;
      endcase
    end
  end

  assign isEq = eqRaw & ~unordered;
  assign isLt = ltRaw & ~unordered;

endmodule

// File: rtl/fcc_datapath.sv
// Control word, compare write-back and register moves
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GPR_W    = 64,
  parameter int IDX_W    = 5,
  parameter int EXP_W    = 8,
  parameter int FLAG_BIT = 23,
  parameter int CTRL_SEL = 31,
  parameter logic [DATA_W-1:0] CTRL0_VAL = 32'h0000_2E30
) (
  input  logic              clk,
  input  logic              rstN,
  input  fccStrobe_t        strobe,
  input  logic [IDX_W-1:0]  fsIdx,
  input  logic [IDX_W-1:0]  rtIdx,
  input  logic [DATA_W-1:0] fsVal,
  input  logic [DATA_W-1:0] ftVal,
  input  logic [DATA_W-1:0] gprIn,
  output logic [DATA_W-1:0] ctrlStatus,
  output logic              condFlag,
  output logic              gprWe,
  output logic [IDX_W-1:0]  gprIdx,
  output logic [GPR_W-1:0]  gprData
);

  localparam int MAN_W = DATA_W - EXP_W - 1;
  localparam int EXT_W = GPR_W - DATA_W;
  localparam logic [IDX_W-1:0] SEL_IDX  = IDX_W'(CTRL_SEL);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic [DATA_W-1:0] ctrlReg, ctrlNext;
  logic              cmpEq, cmpLt, relHolds;
  logic              wrNext;
  logic [DATA_W-1:0] moveWord;
  logic              readAllowed;

  fcc_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
    .opA (fsVal),
    .opB (ftVal),
    .isEq(cmpEq),
    .isLt(cmpLt)
  );

  always_comb begin
    case (strobe.rel)
      REL_EQ:  relHolds = cmpEq;
      REL_LT:  relHolds = cmpLt;
      REL_LE:  relHolds = cmpLt | cmpEq;
      default: relHolds = 1'b0;
    endcase
  end

  always_comb begin
    ctrlNext = ctrlReg;
    if (strobe.ctlWr && fsIdx == SEL_IDX) begin
      ctrlNext = gprIn;
    end else if (strobe.cmpEn) begin
      ctrlNext[FLAG_BIT] = relHolds;
    end
  end

  assign readAllowed = (fsIdx == ZERO_IDX) || (fsIdx == SEL_IDX);

  always_comb begin
    wrNext   = 1'b0;
    moveWord = '0;
    if (rtIdx != ZERO_IDX) begin
      if (strobe.fpMove) begin
        wrNext   = 1'b1;
        moveWord = fsVal;
      end else if (strobe.ctlRd && readAllowed) begin
        wrNext   = 1'b1;
        moveWord = (fsIdx == ZERO_IDX) ? CTRL0_VAL : ctrlReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      gprWe   <= 1'b0;
      gprIdx  <= '0;
      gprData <= '0;
    end else begin
      ctrlReg <= ctrlNext;
      gprWe   <= wrNext;
      gprIdx  <= wrNext ? rtIdx : ZERO_IDX;
      gprData <= wrNext ? {{EXT_W{moveWord[DATA_W-1]}}, moveWord} : '0;
    end
  end

  assign ctrlStatus = ctrlReg;
  assign condFlag   = ctrlReg[FLAG_BIT];

endmodule

// File: rtl/fcc_control.sv
// Operation decode and registered branch decision
module fcc_control
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       condFlag,
  output fccStrobe_t strobe,
  output logic       brValid,
  output logic       brTaken,
  output logic       brSkipSlot
);

  fccOp_e op;
  logic   brEval, brOnTrue, brLikely, takeNow;

  assign op = fccOp_e'(opCode);

  always_comb begin
    strobe   = '0;
    brEval   = 1'b0;
    brOnTrue = 1'b0;
    brLikely = 1'b0;
    if (opValid) begin
      case (op)
        OP_CMP_F:  begin strobe.cmpEn = 1'b1; strobe.rel = REL_FALSE; end
        OP_CMP_EQ: begin strobe.cmpEn = 1'b1; strobe.rel = REL_EQ;    end
        OP_CMP_LT: begin strobe.cmpEn = 1'b1; strobe.rel = REL_LT;    end
        OP_CMP_LE: begin strobe.cmpEn = 1'b1; strobe.rel = REL_LE;    end
        OP_BR_F:   begin brEval = 1'b1; end
        OP_BR_T:   begin brEval = 1'b1; brOnTrue = 1'b1; end
        OP_BR_FL:  begin brEval = 1'b1; brLikely = 1'b1; end
        OP_BR_TL:  begin brEval = 1'b1; brOnTrue = 1'b1; brLikely = 1'b1; end
        OP_MOV_FP: strobe.fpMove = 1'b1;
        OP_CTL_RD: strobe.ctlRd  = 1'b1;
        OP_CTL_WR: strobe.ctlWr  = 1'b1;
        default:   ;
      endcase
    end
  end

  assign takeNow = brEval & (condFlag == brOnTrue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brValid    <= 1'b0;
      brTaken    <= 1'b0;
      brSkipSlot <= 1'b0;
    end else begin
      brValid    <= brEval;
      brTaken    <= takeNow;
      brSkipSlot <= brEval & brLikely & ~takeNow;
    end
  end

endmodule

// File: rtl/fp_cond_branch.sv
// Floating-point condition flag and branch unit (top)
module fp_cond_branch
  import fcc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GPR_W    = 64,
  parameter int IDX_W    = 5,
  parameter int EXP_W    = 8,
  parameter int FLAG_BIT = 23,
  parameter int CTRL_SEL = 31,
  parameter logic [DATA_W-1:0] CTRL0_VAL = 32'h0000_2E30,
  localparam int FS_LO = 11,
  localparam int RT_LO = FS_LO + IDX_W,
  localparam int FIELD_HI = RT_LO + IDX_W - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [3:0]            opCode,
  input  logic [FIELD_HI:FS_LO] regFields,
  input  logic [DATA_W-1:0]     fsVal,
  input  logic [DATA_W-1:0]     ftVal,
  input  logic [DATA_W-1:0]     gprIn,
  output logic [DATA_W-1:0]     ctrlStatus,
  output logic                  condFlag,
  output logic                  gprWe,
  output logic [IDX_W-1:0]      gprIdx,
  output logic [GPR_W-1:0]      gprData,
  output logic                  brValid,
  output logic                  brTaken,
  output logic                  brSkipSlot
);

  fccStrobe_t strobe;

  fcc_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCode    (opCode),
    .condFlag  (condFlag),
    .strobe    (strobe),
    .brValid   (brValid),
    .brTaken   (brTaken),
    .brSkipSlot(brSkipSlot)
  );

  fcc_datapath #(
    .DATA_W   (DATA_W),
    .GPR_W    (GPR_W),
    .IDX_W    (IDX_W),
    .EXP_W    (EXP_W),
    .FLAG_BIT (FLAG_BIT),
    .CTRL_SEL (CTRL_SEL),
    .CTRL0_VAL(CTRL0_VAL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fsIdx     (regFields[RT_LO-1:FS_LO]),
    .rtIdx     (regFields[FIELD_HI:RT_LO]),
    .fsVal     (fsVal),
    .ftVal     (ftVal),
    .gprIn     (gprIn),
    .ctrlStatus(ctrlStatus),
    .condFlag  (condFlag),
    .gprWe     (gprWe),
    .gprIdx    (gprIdx),
    .gprData   (gprData)
  );

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import fcc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GPR_W    = 64,
  parameter int IDX_W    = 5,
  parameter int FLAG_BIT = 23,
  parameter int CTRL_SEL = 31
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  opValid,
  input logic [3:0]            opCode,
  input logic [2*IDX_W-1:0]    fields,
  input logic [DATA_W-1:0]     gprIn,
  input logic [DATA_W-1:0]     ctrlStatus,
  input logic                  condFlag,
  input logic                  gprWe,
  input logic [IDX_W-1:0]      gprIdx,
  input logic [GPR_W-1:0]      gprData,
  input logic                  brValid,
  input logic                  brTaken,
  input logic                  brSkipSlot
);

  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;
  localparam int EXT_W = GPR_W - DATA_W;

  logic [IDX_W-1:0] fsF, rtF;
  logic isBranch;
  assign fsF = fields[IDX_W-1:0];
  assign rtF = fields[2*IDX_W-1:IDX_W];
  assign isBranch = opValid && (opCode >= OP_BR_F) && (opCode <= OP_BR_TL);

  assert_cmpf_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP_F) |=>
      (!condFlag && ((ctrlStatus | FLAG_MASK) == ($past(ctrlStatus) | FLAG_MASK))));

  assert_cmp_keeps_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_CMP_EQ || opCode == OP_CMP_LT || opCode == OP_CMP_LE)) |=>
      ((ctrlStatus | FLAG_MASK) == ($past(ctrlStatus) | FLAG_MASK)));

  assert_branch_from_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    brValid |-> $past(isBranch));

  assert_taken_needs_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> brValid);

  assert_skip_only_not_taken_R7: assert property (@(posedge clk) disable iff (!rstN)
    brSkipSlot |-> (brValid && !brTaken));

  assert_ctlrd_bad_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CTL_RD && fsF != '0 && fsF != IDX_W'(CTRL_SEL)) |=> !gprWe);

  assert_no_zero_dest_R8: assert property (@(posedge clk) disable iff (!rstN)
    gprWe |-> (gprIdx != '0));

  assert_ctlwr_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CTL_WR && fsF != IDX_W'(CTRL_SEL)) |=> $stable(ctrlStatus));

  assert_ctlwr_loads_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CTL_WR && fsF == IDX_W'(CTRL_SEL)) |=> (ctrlStatus == $past(gprIn)));

  assert_move_writes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_MOV_FP && rtF != '0) |=> (gprWe && gprIdx == $past(rtF)));

  assert_sign_extended_R10: assert property (@(posedge clk) disable iff (!rstN)
    gprWe |-> (gprData[GPR_W-1:DATA_W] == {EXT_W{gprData[DATA_W-1]}}));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!brValid && !gprWe && $stable(ctrlStatus)));

endmodule

bind fp_cond_branch fcc_checker #(
  .DATA_W(DATA_W), .GPR_W(GPR_W), .IDX_W(IDX_W), .FLAG_BIT(FLAG_BIT), .CTRL_SEL(CTRL_SEL)
) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .fields(regFields),
  .gprIn(gprIn), .ctrlStatus(ctrlStatus), .condFlag(condFlag), .gprWe(gprWe),
  .gprIdx(gprIdx), .gprData(gprData), .brValid(brValid), .brTaken(brTaken),
  .brSkipSlot(brSkipSlot)
);

// File: tb/sim_fp_cond_branch.sv
`timescale 1ns/1ps
module sim_fp_cond_branch;

  localparam real HALF = 10.0;   // 50 MHz
  localparam logic [31:0] C0 = 32'h0000_2E30;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SD = 32'h0000_0001;

  logic        clk = 0, rstN = 0, opValid = 0;
  logic [3:0]  opCode = 0;
  logic [20:11] regFields = 0;
  logic [31:0] fsVal = 0, ftVal = 0, gprIn = 0;
  logic [31:0] ctrlStatus;
  logic        condFlag, gprWe, brValid, brTaken, brSkipSlot;
  logic [4:0]  gprIdx;
  logic [63:0] gprData;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] mCtrl = 0;
  logic        mWe = 0, mBv = 0, mBt = 0, mBs = 0;
  logic [4:0]  mIdx = 0;
  logic [63:0] mData = 0;

  always #(HALF) clk = ~clk;

  fp_cond_branch u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .regFields(regFields),
    .fsVal(fsVal), .ftVal(ftVal), .gprIn(gprIn), .ctrlStatus(ctrlStatus),
    .condFlag(condFlag), .gprWe(gprWe), .gprIdx(gprIdx), .gprData(gprData),
    .brValid(brValid), .brTaken(brTaken), .brSkipSlot(brSkipSlot)
  );

  function automatic bit isNan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic real toReal(logic [31:0] v);
    int  e;
    real m, r;
    e = int'(v[30:23]);
    m = real'(v[22:0]);
    if (e == 0) r = m * (2.0 ** (-149));
    else        r = (1.0 + m / 8388608.0) * (2.0 ** (e - 127));
    return v[31] ? -r : r;
  endfunction

  function automatic logic [31:0] pool(int k);
    case (k % 8)
      0: return P1; 1: return P2; 2: return N1; 3: return N2;
      4: return PZ; 5: return NZ; 6: return QN; default: return SD;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "ctrlStatus", 64'(ctrlStatus), 64'(mCtrl));
    chk(tag, "condFlag", 64'(condFlag), 64'(mCtrl[23]));
    chk(tag, "gprWe", 64'(gprWe), 64'(mWe));
    chk(tag, "gprIdx", 64'(gprIdx), 64'(mIdx));
    chk(tag, "gprData", gprData, mData);
    chk(tag, "brValid", 64'(brValid), 64'(mBv));
    chk(tag, "brTaken", 64'(brTaken), 64'(mBt));
    chk(tag, "brSkipSlot", 64'(brSkipSlot), 64'(mBs));
  endtask

  // one operation per cycle; called at a falling edge
  task automatic step(string tag, logic v, int op, logic [4:0] rt, logic [4:0] fs,
                      logic [31:0] a, logic [31:0] b, logic [31:0] g);
    logic [31:0] nCtrl, word;
    logic nWe, nBv, nBt, nBs, f, rel;
    logic [4:0] nIdx;
    logic [63:0] nData;
    real ra, rb;
    nCtrl = mCtrl; nWe = 0; nIdx = 0; nData = 0; nBv = 0; nBt = 0; nBs = 0;
    f = mCtrl[23];
    ra = toReal(a); rb = toReal(b);
    if (v) begin
      case (op)
        1: nCtrl[23] = 1'b0;
        2, 3, 4: begin
          if (isNan(a) || isNan(b)) rel = 0;
          else if (op == 2) rel = (ra == rb);
          else if (op == 3) rel = (ra < rb);
          else rel = (ra <= rb);
          nCtrl[23] = rel;
        end
        5, 6, 7, 8: begin
          nBv = 1;
          nBt = (op == 6 || op == 8) ? f : !f;
          nBs = (op >= 7) && !nBt;
        end
        9: if (rt != 0) begin nWe = 1; nIdx = rt; nData = {{32{a[31]}}, a}; end
        10: if (rt != 0 && (fs == 0 || fs == 31)) begin
          word = (fs == 0) ? C0 : mCtrl;
          nWe = 1; nIdx = rt; nData = {{32{word[31]}}, word};
        end
        11: if (fs == 31) nCtrl = g;
        default: ;
      endcase
    end
    opValid = v; opCode = 4'(op); regFields = {rt, fs};
    fsVal = a; ftVal = b; gprIn = g;
    @(posedge clk);
    @(negedge clk);
    mCtrl = nCtrl; mWe = nWe; mIdx = nIdx; mData = nData;
    mBv = nBv; mBt = nBt; mBs = nBs;
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    compareAll("R1");                                   // reset state R1
    step("R9",  1, 11, 5'd2, 5'd31, 0, 0, 32'hA5A5_5A5A); // load word, flag=1
    step("R9",  1, 11, 5'd2, 5'd5,  0, 0, 32'h0);          // ignored index
    step("R9",  1, 11, 5'd2, 5'd0,  0, 0, 32'h0);          // ignored index 0
    step("R2",  1, 1,  0, 0, P1, P1, 0);                   // clear, keep others
    step("R2",  1, 1,  0, 0, P1, P1, 0);                   // already clear
    step("R3",  1, 2,  0, 0, P1, P1, 0);
    step("R3",  1, 3,  0, 0, P2, P1, 0);
    step("R3",  1, 4,  0, 0, P1, P1, 0);
    step("R3",  1, 3,  0, 0, P1, P2, 0);
    step("R3",  1, 4,  0, 0, P2, P1, 0);
    step("R4",  1, 2,  0, 0, PZ, NZ, 0);
    step("R4",  1, 3,  0, 0, N2, N1, 0);
    step("R4",  1, 3,  0, 0, N1, N2, 0);
    step("R4",  1, 3,  0, 0, N1, PZ, 0);
    step("R4",  1, 4,  0, 0, NZ, PZ, 0);
    step("R4",  1, 3,  0, 0, NZ, PZ, 0);
    step("R4",  1, 3,  0, 0, PZ, SD, 0);
    step("R5",  1, 2,  0, 0, P1, P1, 0);                   // set first
    step("R5",  1, 2,  0, 0, QN, QN, 0);
    step("R5",  1, 4,  0, 0, P1, P1, 0);
    step("R5",  1, 4,  0, 0, P1, QN, 0);
    step("R5",  1, 3,  0, 0, N1, P1, 0);
    step("R5",  1, 3,  0, 0, QN, P1, 0);
    step("R6",  1, 2,  0, 0, P1, P1, 0);                   // compare, then branch
    step("R6",  1, 6,  0, 0, 0, 0, 0);
    step("R6",  1, 5,  0, 0, 0, 0, 0);
    step("R6",  1, 1,  0, 0, 0, 0, 0);
    step("R6",  1, 5,  0, 0, 0, 0, 0);
    step("R6",  1, 6,  0, 0, 0, 0, 0);
    step("R7",  1, 8,  0, 0, 0, 0, 0);                     // flag 0: skip
    step("R7",  1, 7,  0, 0, 0, 0, 0);                     // taken: no skip
    step("R7",  1, 3,  0, 0, P1, P2, 0);
    step("R7",  1, 7,  0, 0, 0, 0, 0);                     // skip
    step("R7",  1, 8,  0, 0, 0, 0, 0);                     // taken
    step("R8",  1, 10, 5'd3, 5'd31, 0, 0, 0);
    step("R8",  1, 10, 5'd4, 5'd0,  0, 0, 0);
    step("R8",  1, 10, 5'd4, 5'd7,  0, 0, 0);
    step("R8",  1, 10, 5'd0, 5'd31, 0, 0, 0);
    step("R9",  1, 11, 5'd1, 5'd31, 0, 0, 32'h8000_0001);
    step("R8",  1, 10, 5'd6, 5'd31, 0, 0, 0);              // negative sign-extends
    step("R10", 1, 9,  5'd9, 5'd2, 32'h8000_0001, 0, 0);
    step("R10", 1, 9,  5'd31, 5'd2, 32'h7FFF_FFFF, 0, 0);
    step("R10", 1, 9,  5'd0, 5'd2, 32'hFFFF_FFFF, 0, 0);
    step("R11", 1, 0,  5'd9, 5'd31, P1, P1, 32'hFFFF_FFFF);
    step("R11", 1, 9,  5'd17, 5'd1, 32'h1234_5678, 0, 0);   // rt field bits 20:16
    step("R12", 0, 11, 5'd1, 5'd31, 0, 0, 32'h0);
    step("R12", 0, 6,  0, 0, 0, 0, 0);
    step("R12", 0, 1,  0, 0, 0, 0, 0);
    step("R12", 0, 10, 5'd3, 5'd31, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [4:0] rt, fs;
      op = int'($urandom_range(0, 11));
      rt = 5'($urandom_range(0, 3) * 10);
      fs = ($urandom_range(0, 2) == 0) ? 5'd31 : 5'($urandom_range(0, 31));
      step("R3", ($urandom_range(0, 7) != 0), op, rt, fs,
           pool(int'($urandom_range(0, 7))), pool(int'($urandom_range(0, 7))), $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule